// File: doc/BRIEF.md
# Bank-Sliced Low-Power RAM

This block presents one logical RAM with a write port and a read port. Inside, the storage is split into up to four physical banks. All banks have the full data width but only a fraction of the depth. The upper address bits pick one bank, and the lower bits address a word inside it. Only the chosen bank receives a clock enable on an access. The other banks see no enable, so their bit lines and sense logic stay quiet and draw no dynamic power.

Each port has a request and a user clock enable. The enable that reaches a bank is the request ANDed with the user enable and with the bank decode. Read data comes back one cycle after the request. It passes through an output multiplexer that is steered by a registered copy of the bank index. When no read is issued, the output keeps its last value. Each bank also has a saturating counter of its active cycles, which makes the gating observable.

Top module: `bank_part_ram`

## Requirements
- R1: Address bits [ADDR_W-1:LOC_W] (default [9:8]) select the bank, and bits [LOC_W-1:0] address a word inside it. A word written at any logical address reads back unchanged from that address.
- R2: In any cycle, at most one bit of `bank_wr_en` and at most one bit of `bank_rd_en` is high. Bit b of either vector is high exactly when that port's request and user clock enable are both high and the address selects bank b.
- R3: If a port's request or its user clock enable is low, that port enables no bank. A write in such a cycle leaves the memory unchanged, and a read in such a cycle leaves `rd_data` unchanged.
- R4: A read accepted at a clock edge drives the addressed word on `rd_data` right after that edge, which is one cycle of latency.
- R5: When no read is accepted, `rd_data` holds the last data returned, even when writes go to the bank it came from.
- R6: A read and a write to the same address in the same cycle return the word held before the write.
- R7: Counter b (field `act_count[b*CNT_W +: CNT_W]`, bank 0 in the least significant bits) rises by one in each cycle in which bank b has a read or a write enable. A cycle with both enables counts once. The counter stops at 2^CNT_W-1.
- R8: After a synchronous active-high reset, `rd_data` is zero and every activity counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write request |
| wr_ce | input | 1 | User clock enable for the write port |
| wr_addr | input | ADDR_W | Logical write address |
| wr_data | input | DATA_W | Write data |
| rd_req | input | 1 | Read request |
| rd_ce | input | 1 | User clock enable for the read port |
| rd_addr | input | ADDR_W | Logical read address |
| rd_data | output | DATA_W | Read data, one cycle after an accepted read |
| bank_wr_en | output | NUM_BANKS | Per-bank write clock enable |
| bank_rd_en | output | NUM_BANKS | Per-bank read clock enable |
| act_count | output | NUM_BANKS*CNT_W | Per-bank saturating activity counters |

## Verification
The assertions assume that every address falls inside an existing bank. This holds at the default of four banks, because any address then decodes to a real bank. They also assume that request and enable inputs are never unknown after reset. The stimulus first fills every logical address, so no read ever returns uninitialised storage. It then mixes random requests and enables with directed cases for gated writes, same-address collisions and held outputs. A second instance with a narrow counter runs long enough to reach saturation.

// File: rtl/bank_part_pkg.sv
`timescale 1ns/1ps
package bank_part_pkg;

    // number of address bits spent on bank choice
    function automatic int sel_bits(input int nb);
        return (nb > 1) ? $clog2(nb) : 0;
    endfunction

    // register width that stays legal for a single bank
    function automatic int idx_bits(input int nb);
        return (nb > 1) ? $clog2(nb) : 1;
    endfunction

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_READ  = 2'b10,
        ACC_BOTH  = 2'b11
    } acc_kind_e;

    function automatic acc_kind_e kind_of(input logic wr, input logic rd);
        return acc_kind_e'({rd, wr});
    endfunction

endpackage

// File: rtl/bank_part_decode.sv
`timescale 1ns/1ps
module bank_part_decode #(
    parameter int ADDR_W    = 10,
    parameter int NUM_BANKS = 4,
    parameter int SEL_W     = 2,
    parameter int IDX_W     = 2
) (
    input  logic                 req,
    input  logic                 ce,
    input  logic [ADDR_W-1:0]    addr,
    output logic [IDX_W-1:0]     idx,
    output logic [NUM_BANKS-1:0] en
);
    logic fire;
    assign fire = req & ce;

    generate
        if (SEL_W == 0) begin : g_single
            assign idx = '0;
        end else begin : g_multi
            assign idx = addr[ADDR_W-1 -: SEL_W];
        end
    endgenerate

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_en
            assign en[b] = fire & (idx == IDX_W'(b));
        end
    endgenerate
endmodule

// File: rtl/bank_part_bank.sv
`timescale 1ns/1ps
module bank_part_bank #(
    parameter int LOC_W  = 8,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [LOC_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [LOC_W-1:0]  raddr,
    output logic [DATA_W-1:0] q
);
    localparam int DEPTH = 1 << LOC_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // read samples the old word; write lands at the same edge
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (re) begin
            q <= mem[raddr];
        end
    end
endmodule

// File: rtl/bank_part_rdmux.sv
`timescale 1ns/1ps
module bank_part_rdmux #(
    parameter int NUM_BANKS = 4,
    parameter int DATA_W    = 4,
    parameter int IDX_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        fire,
    input  logic [IDX_W-1:0]            idx,
    input  logic [NUM_BANKS*DATA_W-1:0] bank_q,
    output logic [DATA_W-1:0]           dout
);
    logic [IDX_W-1:0] idx_q;

    // select follows the data returned by the synchronous banks
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (fire) begin
            idx_q <= idx;
        end
    end

    always_comb begin
        dout = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (idx_q == IDX_W'(b)) begin
                dout = bank_q[b*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/bank_part_activity.sv
`timescale 1ns/1ps
module bank_part_activity #(
    parameter int NUM_BANKS = 4,
    parameter int CNT_W     = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_BANKS-1:0]       act,
    output logic [NUM_BANKS*CNT_W-1:0] counts
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cnt
            logic [CNT_W-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt <= '0;
                end else if (act[b] && cnt != CNT_MAX) begin
                    cnt <= cnt + 1'b1;
                end
            end
            assign counts[b*CNT_W +: CNT_W] = cnt;
        end
    endgenerate
endmodule

// File: rtl/bank_part_ram.sv
`timescale 1ns/1ps
module bank_part_ram
    import bank_part_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 4,
    parameter int NUM_BANKS = 4,
    parameter int CNT_W     = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_req,
    input  logic                       wr_ce,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       rd_req,
    input  logic                       rd_ce,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_BANKS-1:0]       bank_wr_en,
    output logic [NUM_BANKS-1:0]       bank_rd_en,
    output logic [NUM_BANKS*CNT_W-1:0] act_count
);
    localparam int SEL_W = sel_bits(NUM_BANKS);
    localparam int IDX_W = idx_bits(NUM_BANKS);
    localparam int LOC_W = ADDR_W - SEL_W;

    generate
        if (NUM_BANKS < 1 || NUM_BANKS > 4) begin : g_bad_banks
            $error("bank_part_ram: NUM_BANKS must be 1 to 4");
        end
    endgenerate

    logic [IDX_W-1:0]            wr_idx;
    logic [IDX_W-1:0]            rd_idx;
    logic [NUM_BANKS*DATA_W-1:0] bank_q;
    logic [NUM_BANKS-1:0]        bank_act;
    acc_kind_e                   bank_kind [NUM_BANKS];

    bank_part_decode #(
        .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W), .IDX_W(IDX_W)
    ) u_wr_dec (
        .req(wr_req), .ce(wr_ce), .addr(wr_addr), .idx(wr_idx), .en(bank_wr_en)
    );

    bank_part_decode #(
        .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W), .IDX_W(IDX_W)
    ) u_rd_dec (
        .req(rd_req), .ce(rd_ce), .addr(rd_addr), .idx(rd_idx), .en(bank_rd_en)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            bank_part_bank #(.LOC_W(LOC_W), .DATA_W(DATA_W)) u_bank (
                .clk  (clk),
                .rst  (rst),
                .we   (bank_wr_en[b]),
                .waddr(wr_addr[LOC_W-1:0]),
                .wdata(wr_data),
                .re   (bank_rd_en[b]),
                .raddr(rd_addr[LOC_W-1:0]),
                .q    (bank_q[b*DATA_W +: DATA_W])
            );
            assign bank_kind[b] = kind_of(bank_wr_en[b], bank_rd_en[b]);
            assign bank_act[b]  = (bank_kind[b] != ACC_IDLE);
        end
    endgenerate

    bank_part_rdmux #(
        .NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_rdmux (
        .clk(clk), .rst(rst), .fire(|bank_rd_en), .idx(rd_idx),
        .bank_q(bank_q), .dout(rd_data)
    );

    bank_part_activity #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)) u_act (
        .clk(clk), .rst(rst), .act(bank_act), .counts(act_count)
    );
endmodule

// File: rtl/bank_part_chk.sv
`timescale 1ns/1ps
module bank_part_chk #(
    parameter int DATA_W    = 4,
    parameter int NUM_BANKS = 4,
    parameter int CNT_W     = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       wr_req,
    input logic                       wr_ce,
    input logic                       rd_req,
    input logic                       rd_ce,
    input logic [DATA_W-1:0]          rd_data,
    input logic [NUM_BANKS-1:0]       bank_wr_en,
    input logic [NUM_BANKS-1:0]       bank_rd_en,
    input logic [NUM_BANKS*CNT_W-1:0] act_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R2
    wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_wr_en));

    // R2
    rd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_rd_en));

    // R2
    wr_one_active_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wr_ce) |-> $countones(bank_wr_en) == 1);

    // R3
    wr_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_req && wr_ce) |-> bank_wr_en == '0);

    // R3
    rd_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && rd_ce) |-> bank_rd_en == '0);

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && rd_ce) |=> $stable(rd_data));

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cnt_chk
            // R7
            cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
                ((bank_wr_en[b] || bank_rd_en[b]) &&
                 act_count[b*CNT_W +: CNT_W] != CNT_MAX)
                |=> act_count[b*CNT_W +: CNT_W] ==
                    $past(act_count[b*CNT_W +: CNT_W]) + 1'b1);
            // R7
            cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
                !(bank_wr_en[b] || bank_rd_en[b])
                |=> $stable(act_count[b*CNT_W +: CNT_W]));
        end
    endgenerate
endmodule

bind bank_part_ram bank_part_chk #(
    .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_ce(wr_ce),
    .rd_req(rd_req), .rd_ce(rd_ce), .rd_data(rd_data),
    .bank_wr_en(bank_wr_en), .bank_rd_en(bank_rd_en), .act_count(act_count)
);

// File: tb/bank_part_ram_tb.sv
`timescale 1ns/1ps
module bank_part_ram_tb;
    localparam int AW = 10;
    localparam int DW = 4;
    localparam int NB = 4;
    localparam int CW = 16;
    localparam int SW = 4;
    localparam int LW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_req = 0, wr_ce = 0, rd_req = 0, rd_ce = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data, s_rd_data;
    logic [NB-1:0] bank_wr_en, bank_rd_en, s_wen, s_ren;
    logic [NB*CW-1:0] act_count;
    logic [NB*SW-1:0] s_count;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [DW-1:0] mdl_mem [1 << AW];
    logic [DW-1:0] exp_rd;
    int            exp_cnt [NB];

    always #2.5 clk = ~clk;

    bank_part_ram #(.ADDR_W(AW), .DATA_W(DW), .NUM_BANKS(NB), .CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .wr_req(wr_req), .wr_ce(wr_ce), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_req(rd_req), .rd_ce(rd_ce), .rd_addr(rd_addr),
        .rd_data(rd_data), .bank_wr_en(bank_wr_en), .bank_rd_en(bank_rd_en),
        .act_count(act_count)
    );

    bank_part_ram #(.ADDR_W(AW), .DATA_W(DW), .NUM_BANKS(NB), .CNT_W(SW)) u_sat (
        .clk(clk), .rst(rst), .wr_req(wr_req), .wr_ce(wr_ce), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_req(rd_req), .rd_ce(rd_ce), .rd_addr(rd_addr),
        .rd_data(s_rd_data), .bank_wr_en(s_wen), .bank_rd_en(s_ren),
        .act_count(s_count)
    );

    function automatic logic [NB-1:0] exp_en(input logic req, input logic ce,
                                             input logic [AW-1:0] a);
        if (req && ce) return NB'(1) << a[AW-1:LW];
        return '0;
    endfunction

    function automatic int sat_of(input int v);
        return (v > 15) ? 15 : v;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_counts(input string req);
        for (int b = 0; b < NB; b++) begin
            chk(act_count[b*CW +: CW] == CW'(exp_cnt[b]), req,
                act_count[b*CW +: CW], exp_cnt[b]);
            chk(s_count[b*SW +: SW] == SW'(sat_of(exp_cnt[b])), "R7 saturate",
                s_count[b*SW +: SW], sat_of(exp_cnt[b]));
        end
    endtask

    // one cycle: drive, check enables, clock, update model, check outputs
    task automatic step(input logic wq, input logic wc, input logic [AW-1:0] wa,
                        input logic [DW-1:0] wd, input logic rq, input logic rc,
                        input logic [AW-1:0] ra, input string rtag);
        logic [NB-1:0] ew, er;
        wr_req = wq; wr_ce = wc; wr_addr = wa; wr_data = wd;
        rd_req = rq; rd_ce = rc; rd_addr = ra;
        #1;
        ew = exp_en(wq, wc, wa);
        er = exp_en(rq, rc, ra);
        chk(bank_wr_en == ew, (wq && wc) ? "R2 write decode" : "R3 write gated",
            bank_wr_en, ew);
        chk(bank_rd_en == er, (rq && rc) ? "R2 read decode" : "R3 read gated",
            bank_rd_en, er);
        @(posedge clk);
        if (rq && rc) exp_rd = mdl_mem[ra];
        if (wq && wc) mdl_mem[wa] = wd;
        for (int b = 0; b < NB; b++)
            if (ew[b] || er[b]) exp_cnt[b]++;
        #1;
        chk(rd_data == exp_rd, rtag, rd_data, exp_rd);
    endtask

    initial begin
        void'($urandom(32'h1d2c3b4a));
        exp_rd = '0;
        for (int b = 0; b < NB; b++) exp_cnt[b] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R8 reset state
        chk(rd_data == '0, "R8 rd_data after reset", rd_data, 0);
        check_counts("R8 counters after reset");

        // R1 fill every address; R5 output holds with no reads
        for (int a = 0; a < (1 << AW); a++)
            step(1, 1, AW'(a), DW'(a ^ (a >> 4)), 0, 1, '0, "R5 hold during fill");
        check_counts("R7 counts after fill");

        // R1 / R4 read back one address from each bank
        for (int b = 0; b < NB; b++)
            step(0, 0, '0, '0, 1, 1, AW'(b * 256 + 17), "R4 read latency per bank");

        // R3 write with user enable low is dropped
        step(1, 0, AW'(300), ~mdl_mem[300], 0, 0, '0, "R3 gated write");
        step(0, 0, '0, '0, 1, 1, AW'(300), "R3 gated write leaves memory");
        // R3 read with request but no user enable leaves rd_data
        step(0, 0, '0, '0, 1, 0, AW'(5), "R3 gated read holds output");

        // R6 same address read and write in one cycle
        step(1, 1, AW'(700), ~mdl_mem[700], 1, 1, AW'(700), "R6 read before write");
        step(0, 0, '0, '0, 1, 1, AW'(700), "R6 new data afterwards");

        // R5 writes into the bank that supplied rd_data do not disturb it
        step(1, 1, AW'(701), 4'h9, 0, 0, '0, "R5 hold across write");
        step(1, 1, AW'(700), 4'h3, 0, 1, '0, "R5 hold across write");

        // mixed random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] ra;
            ra = AW'($urandom);
            if (($urandom % 8) == 0) ra = wr_addr;
            step(($urandom % 4) != 0, ($urandom % 4) != 0, AW'($urandom), DW'($urandom),
                 ($urandom % 3) != 0, ($urandom % 4) != 0, ra, "R4 R6 random read data");
            if ((i % 500) == 0) check_counts("R7 counts random");
        end
        check_counts("R7 counts at end");

        // R8 reset again clears counters and output
        rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        for (int b = 0; b < NB; b++) exp_cnt[b] = 0;
        exp_rd = '0;
        chk(rd_data == '0, "R8 rd_data after second reset", rd_data, 0);
        check_counts("R8 counters after second reset");

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule